// File: doc/BRIEF.md
# Bidirectional Port with Read-Modify-Write Bit Commands

This block is an eight-pin general-purpose port. Each pin has a direction bit and a data bit. A pin whose direction bit is 1 drives its data bit onto the pad. A pin whose direction bit is 0 is an input. On an input pin, a data bit of 1 turns on the weak pull-up for that pin. A small register bus lets software do the following:
- read the port;
- read the raw direction and data registers;
- replace the direction or data register with a full byte;
- issue single-bit set and clear commands.

A bit command runs as a three-cycle read-modify-write. It reads the port through the normal read path, in which input pins report their synchronized pad level. It then forces one bit and writes the whole byte back to the data register. Any input pin whose pad level differs from its stored data bit is therefore rewritten, and its pull-up enable moves with it. Software that must keep pull-ups untouched keeps a shadow byte in memory, edits that, and stores it with a plain byte write.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset the direction register and the data register are both 0x00. pad_oe, pad_out, pad_pu and busy are all 0.
- R2: pad_oe equals the direction register and pad_out equals the data register.
- R3: pad_pu bit i is 1 exactly when direction bit i is 0 and data bit i is 1. It is never 1 on an output pin.
- R4: A read at address 0 returns, for each bit, the data bit if the pin is an output and the synchronized pad level if it is an input. A pad change becomes visible after two rising clock edges.
- R5: A read at address 1 returns the direction register. A read at address 2 returns the raw data register.
- R6: A write at address 0 or address 2 replaces the data register with the written byte exactly. A write at address 1 replaces the direction register.
- R7: A bit command at address 3 with wdata[7]=1 samples the address-0 read value, sets bit wdata[2:0], and writes all 8 bits to the data register. For example, with data 0x80, direction 0x3F and pad input 0x40, setting bit 0 yields data 0x41 and moves the pull-up from bit 7 to bit 6.
- R8: A bit command at address 3 with wdata[7]=0 performs the same sequence but clears bit wdata[2:0].
- R9: busy is high for exactly the three cycles after the clock edge that accepts a bit command. done is high for one cycle right after busy falls, and the new data is visible in that same cycle.
- R10: While busy is high, every bus write is ignored, including further bit commands. Direction and data keep the values that the running sequence gives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data or bit-command word |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| busy | output | 1 | Read-modify-write in progress |
| done | output | 1 | One-cycle completion pulse |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
A fault in the captured read byte or in the bit-forcing step shows at the ports in the cycle that done rises. At that point pad_out, pad_pu and the address-2 read already carry the wrong byte. A sequencer that holds busy for the wrong length shows up one cycle early or late against the three-cycle window. A missing or extra synchronizer stage shows as the port read changing one edge off from the second edge after a pad change. A write that leaks through while busy corrupts the direction or data register. That corruption is visible on pad_oe or pad_out the cycle after the write.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_READ   = 2'd1,
      SQ_MODIFY = 2'd2,
      SQ_WRITE  = 2'd3
   } seq_state_t;

   localparam int unsigned ADR_W = 2;
   localparam logic [ADR_W-1:0] ADR_PORT   = 2'd0;
   localparam logic [ADR_W-1:0] ADR_DIR    = 2'd1;
   localparam logic [ADR_W-1:0] ADR_DATA   = 2'd2;
   localparam logic [ADR_W-1:0] ADR_BITCMD = 2'd3;
endpackage

// File: rtl/gpio_rmw_sync.sv
module gpio_rmw_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_rmw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_rmw_pinctl.sv
module gpio_rmw_pinctl #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] data_q,
   input  logic [W-1:0] pad_sync,
   output logic [W-1:0] port_view,
   output logic [W-1:0] pu_en
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         assign port_view[i] = dir_q[i] ? data_q[i] : pad_sync[i];
         assign pu_en[i]     = ~dir_q[i] & data_q[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_rmw_seq.sv
module gpio_rmw_seq
   import gpio_rmw_pkg::*;
#(
   parameter int unsigned W     = 8,
   parameter int unsigned IDX_W = $clog2(W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             op_set,
   input  logic [IDX_W-1:0] idx,
   input  logic [W-1:0]     port_view,
   output logic             busy,
   output logic             done,
   output logic             wb_en,
   output logic [W-1:0]     wb_data
);
   seq_state_t       state_q;
   logic [W-1:0]     work_q;
   logic             op_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         work_q  <= '0;
         op_q    <= 1'b0;
         idx_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= (state_q == SQ_WRITE);
         case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  op_q    <= op_set;
                  idx_q   <= idx;
                  state_q <= SQ_READ;
               end
            end
            SQ_READ: begin
               work_q  <= port_view;
               state_q <= SQ_MODIFY;
            end
            SQ_MODIFY: begin
               for (int b = 0; b < W; b++) begin
                  if (idx_q == IDX_W'(b)) work_q[b] <= op_q;
               end
               state_q <= SQ_WRITE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != SQ_IDLE);
   assign wb_en   = (state_q == SQ_WRITE);
   assign wb_data = work_q;
endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
   import gpio_rmw_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_valid,
   input  logic             bus_write,
   input  logic [1:0]       bus_addr,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   output logic             busy,
   output logic             done,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu
);
   localparam int unsigned IDX_W  = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam int unsigned OP_BIT = WIDTH - 1;

   generate
      if (WIDTH < 2 || IDX_W >= WIDTH) begin : g_bad_width
         $error("gpio_rmw_port: WIDTH too small for the bit-command word");
      end
   endgenerate

   logic [WIDTH-1:0] dir_q, data_q, pad_sync, port_view, wb_data;
   logic             accept, wr_dir, wr_data, cmd_start, wb_en;

   assign accept    = bus_valid & bus_write & ~busy;
   assign wr_dir    = accept & (bus_addr == ADR_DIR);
   assign wr_data   = accept & ((bus_addr == ADR_PORT) | (bus_addr == ADR_DATA));
   assign cmd_start = accept & (bus_addr == ADR_BITCMD);

   gpio_rmw_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   gpio_rmw_pinctl #(.W(WIDTH)) u_pinctl (
      .dir_q     (dir_q),
      .data_q    (data_q),
      .pad_sync  (pad_sync),
      .port_view (port_view),
      .pu_en     (pad_pu)
   );

   gpio_rmw_seq #(.W(WIDTH), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd_start),
      .op_set    (bus_wdata[OP_BIT]),
      .idx       (bus_wdata[IDX_W-1:0]),
      .port_view (port_view),
      .busy      (busy),
      .done      (done),
      .wb_en     (wb_en),
      .wb_data   (wb_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         data_q <= '0;
      end else begin
         if (wr_dir)       dir_q  <= bus_wdata;
         if (wb_en)        data_q <= wb_data;
         else if (wr_data) data_q <= bus_wdata;
      end
   end

   always_comb begin
      case (bus_addr)
         ADR_PORT: bus_rdata = port_view;
         ADR_DIR:  bus_rdata = dir_q;
         ADR_DATA: bus_rdata = data_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign pad_oe  = dir_q;
   assign pad_out = data_q;
endmodule

// File: rtl/gpio_rmw_chk.sv
module gpio_rmw_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_valid,
   input logic             bus_write,
   input logic [1:0]       bus_addr,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_pu
);
   AST_PU_OFF_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0); // R3

   AST_BUSY_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy); // R9

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ##2 busy ##1 !busy); // R9

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R9

   AST_DIR_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(pad_oe)); // R10

   AST_DATA_WRITE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pad_out) |-> (done || $past(bus_valid && bus_write && !busy &&
                                     (bus_addr == 2'd0 || bus_addr == 2'd2)))); // R6
endmodule

bind gpio_rmw_port gpio_rmw_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .busy      (busy),
   .done      (done),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .pad_pu    (pad_pu)
);

// File: tb/gpio_rmw_port_bench.sv
module gpio_rmw_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_valid = 1'b0;
   logic       bus_write = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       busy, done;
   logic [7:0] pad_in = 8'h00;
   logic [7:0] pad_oe, pad_out, pad_pu;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   gpio_rmw_port u_gpio_rmw_port (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .pad_in(pad_in), .pad_oe(pad_oe),
      .pad_out(pad_out), .pad_pu(pad_pu)
   );

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Bit command with R9 timing checks; returns with done high, new data visible.
   task automatic bitcmd(logic set, logic [2:0] idx);
      wr(2'd3, {set, 4'b0000, idx});
      chk("R9", "busy cycle1", {7'd0, busy}, 8'd1);
      wait_clk(1);
      chk("R9", "busy cycle2", {7'd0, busy}, 8'd1);
      wait_clk(1);
      chk("R9", "busy cycle3", {7'd0, busy}, 8'd1);
      wait_clk(1);
      chk("R9", "busy low/done high", {6'd0, busy, done}, 8'b01);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1", "pad_oe", pad_oe, 8'h00);
      chk("R1", "pad_out", pad_out, 8'h00);
      chk("R1", "pad_pu", pad_pu, 8'h00);
      chk("R1", "busy", {7'd0, busy}, 8'h00);
      rd(2'd1, v); chk("R1", "dir reg", v, 8'h00);
      rd(2'd2, v); chk("R1", "data reg", v, 8'h00);
   endtask

   task automatic t_regs();
      logic [7:0] v;
      wr(2'd1, 8'hF0);
      wr(2'd2, 8'hA5);
      chk("R2", "pad_oe", pad_oe, 8'hF0);
      chk("R2", "pad_out", pad_out, 8'hA5);
      chk("R3", "pad_pu", pad_pu, 8'h05);
      rd(2'd1, v); chk("R5", "dir read", v, 8'hF0);
      rd(2'd2, v); chk("R5", "data read", v, 8'hA5);
   endtask

   task automatic t_port_read();
      logic [7:0] v;
      @(negedge clk);
      pad_in = 8'h3C;
      bus_addr = 2'd0;
      @(posedge clk); #1;
      chk("R4", "port after 1 edge", bus_rdata, 8'hA0);
      @(posedge clk); #1;
      chk("R4", "port after 2 edges", bus_rdata, 8'hAC);
      wr(2'd0, 8'h5A);
      rd(2'd2, v); chk("R6", "byte write via addr0", v, 8'h5A);
   endtask

   task automatic t_set_side_effect();
      logic [7:0] v;
      wr(2'd1, 8'h3F);
      wr(2'd2, 8'h80);
      @(negedge clk); pad_in = 8'h40;
      wait_clk(3);
      rd(2'd0, v); chk("R4", "port read mixed", v, 8'h40);
      chk("R3", "pull-up before", pad_pu, 8'h80);
      bitcmd(1'b1, 3'd0);
      chk("R7", "data after set", pad_out, 8'h41);
      chk("R7", "pull-up moved", pad_pu, 8'h40);
      rd(2'd2, v); chk("R7", "raw data read", v, 8'h41);
      // byte write keeps pull-ups exactly as written
      wr(2'd2, 8'h81);
      chk("R6", "byte write exact", pad_out, 8'h81);
      chk("R3", "pull-up after byte write", pad_pu, 8'h80);
   endtask

   task automatic t_clear();
      logic [7:0] v;
      wr(2'd1, 8'h0F);
      wr(2'd2, 8'hFF);
      @(negedge clk); pad_in = 8'h30;
      wait_clk(3);
      bitcmd(1'b0, 3'd1);
      rd(2'd2, v); chk("R8", "data after clear", v, 8'h3D);
      chk("R8", "pull-ups after clear", pad_pu, 8'h30);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] v;
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);
      @(negedge clk); pad_in = 8'h00;
      wait_clk(3);
      wr(2'd3, 8'h87);
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h11);
      wr(2'd3, 8'h82);
      wait_clk(3);
      chk("R10", "busy cleared", {7'd0, busy}, 8'h00);
      rd(2'd1, v); chk("R10", "dir unchanged", v, 8'h00);
      rd(2'd2, v); chk("R10", "data from sequence only", v, 8'h80);
      chk("R7", "set bit 7 from zero", pad_out, 8'h80);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      wait_clk(2);
      t_reset();
      t_regs();
      t_port_read();
      t_set_side_effect();
      t_clear();
      t_busy_ignore();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule